// File: doc/BRIEF.md
# Indexed Bit-Operation Execution Unit

This unit carries out the indexed rotate, shift, bit-test, bit-clear and bit-force instructions of an 8-bit accumulator processor that has two 16-bit index registers. The instruction fetch logic hands it three things on a start pulse: a select that picks index X or index Y, the signed displacement byte, and the operation byte. The unit adds the displacement to the chosen index register to form the operand address. It then reads the operand byte through a synchronous byte memory port, transforms it, and writes it back.

The operation byte holds three fields. The class field picks one of four classes: shift/rotate, bit test, bit clear or bit force. A 3-bit field holds either the shift kind or the bit index. A second 3-bit field names a general register. When that register field is not the "none" code, the modified byte is also copied to that register. The unit outputs the result byte and the updated flag byte. It raises a one-cycle done pulse when the operation completes.

Top module: `idx_bitop_unit`

## Requirements
- R1: The operand address is the index register chosen by `use_y_i` (0 = X, 1 = Y) plus the sign-extended displacement, taken modulo 2^AW.
- R2: After the clock edge that accepts `start_i`, the unit presents one read cycle (`mem_rd_o`). Two cycles after that read, a write-back cycle (`mem_wr_o`) follows at the same address. `done_o` is high for exactly one cycle. It is seen 4 cycles after the accepting edge for a modifying operation and 3 cycles after it for a bit test.
- R3: Operation bits [7:6] give the class: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit force. Bits [5:3] give the shift kind or the bit index, and bits [2:0] give the register field.
- R4: The left shift kinds are: 0 circular, with carry taking bit 7; 2 through carry, with old carry into bit 0; 4 shift in 0; 6 shift in 1. Kinds 2, 4 and 6 also move bit 7 into carry.
- R5: The right shift kinds are: 1 circular; 3 through carry, with old carry into bit 7; 5 arithmetic, keeping bit 7; 7 logical, with 0 into bit 7. Each of these moves bit 0 into carry.
- R6: The flag byte layout is bit7 S, bit6 Z, bit4 H, bit2 P, bit1 N, bit0 C, and bits 5 and 3 pass through. A shift sets S to result bit 7 and Z to "result is zero". It sets P to even parity (1 when the count of ones is even), clears H and N, and puts the bit shifted out into C.
- R7: A bit test reads the memory byte and makes no memory write and no register write. It sets Z to the inverse of the tested bit, sets H, clears N, and leaves all other flags unchanged. The result output equals the memory byte.
- R8: Bit clear writes the byte back with the indexed bit at 0, and bit force writes it back with that bit at 1. Both return the input flag byte unchanged.
- R9: For a modifying class, a register field other than 6 raises `reg_we_o` during the write-back cycle. At that time `reg_sel_o` equals the field and `reg_data_o` equals the written byte. Field 6 writes no register.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. It causes no extra memory cycle and does not alter the running operation.
- R11: After reset, `busy_o`, `done_o`, `mem_rd_o`, `mem_wr_o` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| use_y_i | input | 1 | Index select: 0 = X, 1 = Y |
| disp_i | input | 8 | Signed displacement |
| op_i | input | 8 | Operation byte |
| ix_i | input | AW | Index register X |
| iy_i | input | AW | Index register Y |
| flags_i | input | 8 | Current flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | AW | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data is returned the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| reg_we_o | output | 1 | General register write enable |
| reg_sel_o | output | 3 | Register code (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A) |
| reg_data_o | output | 8 | Register write data |
| result_o | output | 8 | Result byte, valid from `done_o` on |
| flags_o | output | 8 | Updated flag byte, valid from `done_o` on |

## Verification
The checker assumes the memory answers a read strobe with data in the following cycle. It also assumes the operands on `op_i`, `disp_i`, the index inputs and `flags_i` are stable at the accepting edge. The bench models the memory with exactly one cycle of read latency. It changes inputs only on the falling edge. Its only start requests made while busy are deliberate pulses with a different operation byte, so the unit must ignore them.

// File: rtl/idx_bitop_pkg.sv
package idx_bitop_pkg;
  localparam int DW = 8;
  localparam int FW = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_READ, ST_MODIFY, ST_WRITE, ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    CL_SHIFT = 2'b00, CL_TEST = 2'b01, CL_CLR = 2'b10, CL_SET = 2'b11
  } op_class_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  localparam logic [FW-1:0] REG_NONE = 3'd6;
endpackage

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int AW = 16
) (
  input  logic          use_y_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [7:0]    disp_i,
  output logic [AW-1:0] addr_o
);
  localparam int EXT = AW - 8;

  logic [AW-1:0] base;
  logic [AW-1:0] disp_ext;

  assign base     = use_y_i ? iy_i : ix_i;
  assign disp_ext = {{EXT{disp_i[7]}}, disp_i};
  assign addr_o   = base + disp_ext;  // wraps modulo 2^AW
endmodule

// File: rtl/idx_bit_alu.sv
module idx_bit_alu
  import idx_bitop_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [7:0]    op_i,
  input  logic [7:0]    flags_i,
  output logic [DW-1:0] result_o,
  output logic [7:0]    flags_o
);
  op_class_e     cls;
  logic [FW-1:0] sel;
  logic          cin;
  logic          cout;
  logic [DW-1:0] shf;
  logic [DW-1:0] mask;

  assign cls = op_class_e'(op_i[7:6]);
  assign sel = op_i[5:3];
  assign cin = flags_i[FL_C];

  always_comb begin
    unique case (sel)
      3'd0: begin shf = {data_i[6:0], data_i[7]}; cout = data_i[7]; end
      3'd1: begin shf = {data_i[0], data_i[7:1]}; cout = data_i[0]; end
      3'd2: begin shf = {data_i[6:0], cin};       cout = data_i[7]; end
      3'd3: begin shf = {cin, data_i[7:1]};       cout = data_i[0]; end
      3'd4: begin shf = {data_i[6:0], 1'b0};      cout = data_i[7]; end
      3'd5: begin shf = {data_i[7], data_i[7:1]}; cout = data_i[0]; end
      3'd6: begin shf = {data_i[6:0], 1'b1};      cout = data_i[7]; end
      default: begin shf = {1'b0, data_i[7:1]};   cout = data_i[0]; end
    endcase
  end

  assign mask = DW'(1) << sel;

  always_comb begin
    result_o = data_i;
    flags_o  = flags_i;
    unique case (cls)
      CL_SHIFT: begin
        result_o       = shf;
        flags_o[FL_S]  = shf[DW-1];
        flags_o[FL_Z]  = (shf == '0);
        flags_o[FL_H]  = 1'b0;
        flags_o[FL_P]  = ~^shf;
        flags_o[FL_N]  = 1'b0;
        flags_o[FL_C]  = cout;
      end
      CL_TEST: begin
        flags_o[FL_Z]  = ~|(data_i & mask);
        flags_o[FL_H]  = 1'b1;
        flags_o[FL_N]  = 1'b0;
      end
      CL_CLR:  result_o = data_i & ~mask;
      default: result_o = data_i | mask;
    endcase
  end
endmodule

// File: rtl/idx_seq_fsm.sv
module idx_seq_fsm
  import idx_bitop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_test_i,
  output logic latch_o,
  output logic addr_en_o,
  output logic rd_o,
  output logic mod_en_o,
  output logic wr_o,
  output logic done_o,
  output logic busy_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_ADDR;
      ST_ADDR:   st_d = ST_READ;
      ST_READ:   st_d = ST_MODIFY;
      ST_MODIFY: st_d = is_test_i ? ST_DONE : ST_WRITE;
      ST_WRITE:  st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign latch_o   = (st_q == ST_IDLE) && start_i;
  assign addr_en_o = (st_q == ST_ADDR);
  assign rd_o      = (st_q == ST_READ);
  assign mod_en_o  = (st_q == ST_MODIFY);
  assign wr_o      = (st_q == ST_WRITE);
  assign done_o    = (st_q == ST_DONE);
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/idx_bitop_unit.sv
module idx_bitop_unit
  import idx_bitop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          use_y_i,
  input  logic [7:0]    disp_i,
  input  logic [7:0]    op_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [7:0]    flags_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          reg_we_o,
  output logic [2:0]    reg_sel_o,
  output logic [7:0]    reg_data_o,
  output logic [7:0]    result_o,
  output logic [7:0]    flags_o
);
  logic          latch, addr_en, mod_en, wr;
  logic          use_y_q;
  logic [7:0]    op_q, disp_q, flags_q;
  logic [AW-1:0] ix_q, iy_q, addr_q, addr_d;
  logic [DW-1:0] res_q, res_d;
  logic [7:0]    fl_q, fl_d;
  logic          is_test;

  assign is_test = (op_class_e'(op_q[7:6]) == CL_TEST);

  idx_seq_fsm u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .is_test_i (is_test),
    .latch_o   (latch),
    .addr_en_o (addr_en),
    .rd_o      (mem_rd_o),
    .mod_en_o  (mod_en),
    .wr_o      (wr),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  idx_addr_gen #(.AW(AW)) u_agen (
    .use_y_i (use_y_q),
    .ix_i    (ix_q),
    .iy_i    (iy_q),
    .disp_i  (disp_q),
    .addr_o  (addr_d)
  );

  idx_bit_alu u_alu (
    .data_i   (mem_rdata_i),
    .op_i     (op_q),
    .flags_i  (flags_q),
    .result_o (res_d),
    .flags_o  (fl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_y_q <= 1'b0;
      op_q    <= '0;
      disp_q  <= '0;
      flags_q <= '0;
      ix_q    <= '0;
      iy_q    <= '0;
    end else if (latch) begin
      use_y_q <= use_y_i;
      op_q    <= op_i;
      disp_q  <= disp_i;
      flags_q <= flags_i;
      ix_q    <= ix_i;
      iy_q    <= iy_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      fl_q  <= '0;
    end else if (mod_en) begin
      res_q <= res_d;
      fl_q  <= fl_d;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wr_o    = wr;
  assign mem_wdata_o = res_q;
  assign reg_sel_o   = op_q[2:0];
  assign reg_we_o    = wr && (op_q[2:0] != REG_NONE);
  assign reg_data_o  = res_q;
  assign result_o    = res_q;
  assign flags_o     = fl_q;
endmodule

// File: rtl/idx_bitop_chk.sv
module idx_bitop_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          reg_we_o,
  input logic [2:0]    reg_sel_o,
  input logic [7:0]    reg_data_o,
  input logic [7:0]    mem_wdata_o,
  input logic [7:0]    op_q,
  input logic [7:0]    flags_q,
  input logic [7:0]    flags_o
);
  a_r2_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r2_wr_follows_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r7_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> op_q[7:6] != 2'b01);

  a_r8_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q[7]) |-> flags_o == flags_q);

  a_r9_reg_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (mem_wr_o && reg_sel_o != 3'd6 && reg_data_o == mem_wdata_o));

  a_r10_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(op_q));
endmodule

bind idx_bitop_unit idx_bitop_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .reg_we_o    (reg_we_o),
  .reg_sel_o   (reg_sel_o),
  .reg_data_o  (reg_data_o),
  .mem_wdata_o (mem_wdata_o),
  .op_q        (op_q),
  .flags_q     (flags_q),
  .flags_o     (flags_o)
);

// File: tb/tb_idx_bitop_unit.sv
`timescale 1ns/1ps
module tb_idx_bitop_unit;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, use_y = 0;
  logic [7:0] disp = 0, op = 0, flags = 0;
  logic [AW-1:0] ix = 0, iy = 0;
  logic busy, done, mem_rd, mem_wr, reg_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] wdata, rdata, reg_data, result, fl_out;
  logic [2:0] reg_sel;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [256];
  int rd_cnt = 0, wr_cnt = 0, reg_cnt = 0;
  logic [AW-1:0] rd_addr_cap;
  logic [2:0] reg_sel_cap;
  logic [7:0] reg_data_cap;

  always #2 clk = ~clk;

  idx_bitop_unit #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .use_y_i(use_y),
    .disp_i(disp), .op_i(op), .ix_i(ix), .iy_i(iy), .flags_i(flags),
    .busy_o(busy), .done_o(done), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .reg_we_o(reg_we), .reg_sel_o(reg_sel), .reg_data_o(reg_data),
    .result_o(result), .flags_o(fl_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      rdata <= mem[mem_addr[7:0]];
      rd_addr_cap <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_we) begin
      reg_cnt <= reg_cnt + 1;
      reg_sel_cap <= reg_sel;
      reg_data_cap <= reg_data;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model written from R4..R8
  function automatic logic [15:0] model(logic [7:0] d, logic [7:0] o, logic [7:0] f);
    logic [7:0] r = d, g = f;
    logic c = f[0];
    logic [2:0] k = o[5:3];
    case (o[7:6])
      2'b00: begin
        case (k)
          0: begin r = {d[6:0], d[7]}; c = d[7]; end
          1: begin r = {d[0], d[7:1]}; c = d[0]; end
          2: begin r = {d[6:0], f[0]}; c = d[7]; end
          3: begin r = {f[0], d[7:1]}; c = d[0]; end
          4: begin r = d << 1;         c = d[7]; end
          5: begin r = {d[7], d[7:1]}; c = d[0]; end
          6: begin r = (d << 1) | 8'h01; c = d[7]; end
          default: begin r = d >> 1;   c = d[0]; end
        endcase
        g[7] = r[7]; g[6] = (r == 0); g[4] = 0;
        g[2] = ($countones(r) % 2 == 0); g[1] = 0; g[0] = c;
      end
      2'b01: begin g[6] = !d[k]; g[4] = 1; g[1] = 0; end
      2'b10: r[k] = 1'b0;
      default: r[k] = 1'b1;
    endcase
    return {g, r};
  endfunction

  // one operation; disturb pulses start with another op while busy (R10)
  task automatic run_op(string req, logic y, logic [AW-1:0] base, logic [7:0] d,
                        logic [7:0] o, logic [7:0] f, logic [7:0] init, bit disturb);
    logic [AW-1:0] ea;
    logic [15:0] e;
    bit is_test, regw;
    int n, rd0, wr0, rg0;
    ea = base + {{(AW-8){d[7]}}, d};
    e = model(init, o, f);
    is_test = (o[7:6] == 2'b01);
    regw = !is_test && (o[2:0] != 3'd6);
    mem[ea[7:0]] = init;
    rd0 = rd_cnt; wr0 = wr_cnt; rg0 = reg_cnt;
    use_y = y; disp = d; op = o; flags = f;
    if (y) begin iy = base; ix = ~base; end else begin ix = base; iy = ~base; end
    start = 1;
    @(negedge clk);
    start = 0;
    op = ~o; disp = ~d; flags = ~f; use_y = ~y;
    n = 0;
    while (!done && n < 20) begin
      start = disturb && (n == 1);
      @(negedge clk);
      n++;
    end
    if (disturb) start = 1;
    chk("R2", "done latency", n, is_test ? 3 : 4);
    chk("R1", "read address", rd_addr_cap, ea);
    chk(req, "result", result, e[7:0]);
    chk(req, "flags", fl_out, e[15:8]);
    chk(is_test ? "R7" : req, "memory after", mem[ea[7:0]], is_test ? init : e[7:0]);
    chk(is_test ? "R7" : "R2", "write count", wr_cnt - wr0, is_test ? 0 : 1);
    chk("R9", "reg write count", reg_cnt - rg0, regw ? 1 : 0);
    if (regw) begin
      chk("R9", "reg select", reg_sel_cap, o[2:0]);
      chk("R9", "reg data", reg_data_cap, e[7:0]);
    end
    @(negedge clk);
    start = 0;
    chk("R2", "done single cycle", done, 0);
    if (disturb) begin
      repeat (6) @(negedge clk);
      chk("R10", "reads during busy starts", rd_cnt - rd0, 1);
      chk("R10", "idle after ignored starts", busy, 0);
    end
  endtask

  task automatic t_reset();
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    chk("R11", "mem_rd", mem_rd, 0);
    chk("R11", "mem_wr", mem_wr, 0);
    chk("R11", "reg_we", reg_we, 0);
  endtask

  task automatic t_addr();
    run_op("R1", 0, 16'h1234, 8'h05, 8'hC6, 8'h00, 8'h00, 0);
    run_op("R1", 1, 16'h10F0, 8'h80, 8'hC6, 8'h00, 8'h10, 0);
    run_op("R1", 0, 16'hFFF0, 8'h20, 8'h86, 8'h00, 8'hFF, 0);
    run_op("R1", 1, 16'h0005, 8'hF0, 8'hD6, 8'h00, 8'h00, 0);
  endtask

  task automatic t_shift();
    for (int k = 0; k < 8; k++) begin
      logic [7:0] o = {2'b00, 3'(k), 3'd6};
      run_op((k % 2) ? "R5" : "R4", 0, 16'h0200, 8'h10, o, 8'h00, 8'h81, 0);
      run_op((k % 2) ? "R5" : "R4", 1, 16'h0300, 8'h22, o, 8'h29, 8'h42, 0);
      run_op("R6", 0, 16'h0400, 8'h01, o, 8'hFF, 8'h00, 0);
    end
  endtask

  task automatic t_test();
    for (int b = 0; b < 8; b++) begin
      run_op("R7", 0, 16'h0500, 8'h07, {2'b01, 3'(b), 3'd6}, 8'h01, 8'hA5, 0);
      run_op("R7", 1, 16'h0600, 8'h09, {2'b01, 3'(b), 3'd0}, 8'hAA, 8'h5A, 0);
    end
  endtask

  task automatic t_clr_set();
    run_op("R8", 0, 16'h0700, 8'h00, 8'hBE, 8'hD7, 8'hFF, 0);
    run_op("R8", 1, 16'h0700, 8'h01, 8'hC6, 8'h28, 8'h00, 0);
    run_op("R8", 0, 16'h0700, 8'h02, 8'h9E, 8'h00, 8'h08, 0);
    run_op("R8", 1, 16'h0700, 8'h03, 8'hEE, 8'hFF, 8'h00, 0);
  endtask

  task automatic t_regcopy();
    run_op("R9", 0, 16'h0800, 8'h04, 8'hDF, 8'h00, 8'h00, 0);
    run_op("R9", 1, 16'h0800, 8'h05, 8'h00, 8'h00, 8'h80, 0);
    run_op("R9", 0, 16'h0800, 8'h06, 8'hA5, 8'h00, 8'hFF, 0);
    run_op("R9", 1, 16'h0800, 8'h07, 8'h3B, 8'h00, 8'h03, 0);
  endtask

  task automatic t_busy();
    run_op("R10", 0, 16'h0900, 8'h01, 8'h0E, 8'h00, 8'h81, 1);
    run_op("R10", 1, 16'h0900, 8'h02, 8'h4E, 8'h00, 8'h02, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_addr();      // R1, R3
    t_shift();     // R4, R5, R6
    t_test();      // R7
    t_clr_set();   // R8
    t_regcopy();   // R9
    t_busy();      // R10
    finish_run();
  end
endmodule